// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Line Transmitter

This block turns a stream of stereo PCM words into a two-channel consumer digital audio line signal. Each word fills one half of a frame (a subframe), two subframes make a frame, and 192 frames make a block. The serial bits are biphase-mark coded, and the block runs from an encoder clock at 128 times the sample rate, so every clock cycle emits one half-cell of the line. A frame therefore lasts 128 cycles and a subframe lasts 64.

Every subframe starts with an 8-half-cell sync pattern. The pattern marks the first subframe of a block, a channel-1 subframe or a channel-2 subframe. After the sync come a 24-bit sample, a validity bit, one bit of the per-block user data, one bit of the per-block channel status, and an even parity bit. Software provides the 192-bit status and user banks as flat vectors, six 32-bit words each. At each block start the banks are copied into private shadow registers, and a ready event fires on each copy, so software may rewrite the banks for the next block while the current one is sent.

Samples are pulled, not pushed. `smp_ready` is high for exactly one cycle at each subframe start while the block is transmitting. A word transfers when `smp_valid` is also high in that cycle. The source cannot stall the line. If `smp_valid` is low in the ready cycle, the subframe carries a zero sample and a sticky underrun flag is raised. `smp_data` only needs to be stable in the ready cycle.

Top module: `spdif_line_tx`

## Requirements
- R1: While reset is asserted and right after it, `line_out` is 0, `smp_ready` is 0, all three event outputs are 0 and `underrun_flag` is 0.
- R2: While transmitting, `smp_ready` is high for exactly one cycle at the start of each subframe (every 64 cycles), alternating channel 1 and channel 2. It is low at all other times. A word is taken only when `smp_valid` is high in that cycle.
- R3: Each subframe is 32 slots of two half-cells, with one half-cell per clock. Slots 4 to 27 carry the sample LSB first. Slot 28 carries validity, slot 29 the user bit, slot 30 the status bit, and slot 31 a parity bit that makes slots 4 to 31 even. The line toggles at every slot boundary and also mid-slot when the bit is 1.
- R4: Slots 0 to 3 carry an 8-half-cell sync pattern, sent first-to-last as 11101000 for channel 1 of frame 0, 11100010 for channel 1 of the other frames, and 11100100 for channel 2. The pattern is inverted when the line level just before it is 1.
- R5: With the line idle, a high `tx_en` starts frame 0 of a new block, and its first half-cell appears on `line_out` two cycles after `tx_en` is first sampled high. Clearing `tx_en` lets the current frame finish. The line then drops to 0 and stays there until the next start, which again begins a new block.
- R6: Slot 28 of channel-1 subframes carries `valid_ch1` and slot 28 of channel-2 subframes carries `valid_ch2`, each sampled at the subframe start.
- R7: The status and user bits sent in frame n are bit n of the `cs_bank` and `ud_bank` copies taken at the start of the block (word n/32, bit n%32 of each six-word bank). Bank changes made after the copy only affect the next block.
- R8: `evt_cs_ready` and `evt_ud_ready` each pulse high for one cycle right after the shadow copy at every block start.
- R9: `evt_block_end` pulses high for one cycle right after the last half-cell of frame 191.
- R10: When no word is offered at a subframe start, `underrun_flag` is set and stays set until `underrun_clr` is high in a cycle with no new underrun. The subframe is then sent with a zero sample.
- R11: An underrun subframe sends validity 1 (invalid) when `null_valid` is 0, and validity 0 when `null_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, one half-cell per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; a stop takes effect at the next frame end |
| null_valid | input | 1 | Validity choice for underrun subframes (0: invalid, 1: valid) |
| valid_ch1 | input | 1 | Validity bit for channel-1 subframes |
| valid_ch2 | input | 1 | Validity bit for channel-2 subframes |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| cs_bank | input | 192 | Channel-status bank, bit n for frame n |
| ud_bank | input | 192 | User-data bank, bit n for frame n |
| smp_valid | input | 1 | A sample word is offered |
| smp_ready | output | 1 | One-cycle pull strobe at each subframe start |
| smp_data | input | 24 | Sample word for the subframe being started |
| line_out | output | 1 | Biphase-mark coded line |
| evt_block_end | output | 1 | Pulse after frame 191 is complete |
| evt_cs_ready | output | 1 | Pulse after the status bank was copied |
| evt_ud_ready | output | 1 | Pulse after the user bank was copied |
| underrun_flag | output | 1 | Sticky underrun indication |

## Verification
The assertions check the following on every cycle:
- the forced line toggle at each data-slot boundary;
- the return to the entry level at the end of each sync pattern;
- one-cycle pull and event pulses;
- underrun-flag stickiness;
- a low idle line;
- stops that only happen on a frame boundary.

The exact bit contents can only be shown by the bench's scenarios, which compare the line against a behavioural model on every clock. These contents include parity, sync choice and inversion, the frame-indexed status and user bits, bank changes that land only in the next block, the validity swap, both underrun validity options, and stop and restart.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int HC_PER_SF  = 64;
  localparam int POS_W      = 7;
  localparam int PRE_HC     = 8;
  localparam int SLOT_DATA0 = 4;

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_CH1   = 2'd1,
    SYNC_CH2   = 2'd2
  } sync_e;

  function automatic logic [7:0] sync_bits(sync_e s);
    case (s)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_CH1:   return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/spdif_tx_timing.sv
module spdif_tx_timing import spdif_tx_pkg::*; #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  output logic             running,
  output logic [POS_W-1:0] pos,
  output logic [FW-1:0]    frame,
  output logic             sf_start,
  output logic             blk_start,
  output logic             blk_last
);
  localparam logic [POS_W-1:0] POS_LAST = '1;
  localparam logic [FW-1:0]    FRM_LAST = FW'(FRAMES - 1);

  logic frame_end;
  assign frame_end = running && (pos == POS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pos     <= '0;
      frame   <= '0;
    end else if (!running) begin
      pos   <= '0;
      frame <= '0;
      if (tx_en) running <= 1'b1;
    end else begin
      pos <= pos + 1'b1;
      if (frame_end) begin
        if (!tx_en) begin
          running <= 1'b0;
          frame   <= '0;
        end else begin
          frame <= (frame == FRM_LAST) ? '0 : frame + 1'b1;
        end
      end
    end
  end

  assign sf_start  = running && (pos[5:0] == 6'd0);
  assign blk_start = running && (pos == '0) && (frame == '0);
  assign blk_last  = frame_end && (frame == FRM_LAST);

  p_stop_on_frame_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (pos != POS_LAST)) |=> running);

  p_block_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_last && tx_en) |=> blk_start);
endmodule

// File: rtl/spdif_tx_shadow.sv
module spdif_tx_shadow #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FW-1:0]     frame_idx,
  input  logic [FRAMES-1:0] bank,
  output logic              bit_out,
  output logic              loaded_evt
);
  logic [FRAMES-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      loaded_evt <= 1'b0;
    end else begin
      loaded_evt <= load;
      if (load) shadow_q <= bank;
    end
  end

  assign bit_out = shadow_q[frame_idx];

  p_copy_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_evt |=> !loaded_evt);
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc import spdif_tx_pkg::*; #(
  parameter int DW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic [POS_W-1:0] pos,
  input  sync_e            sync_sel,
  input  logic             load_word,
  input  logic [DW-1:0]    word_in,
  input  logic             v_in,
  input  logic             u_bit,
  input  logic             c_bit,
  output logic             line
);
  localparam int SLOT_V = SLOT_DATA0 + DW;
  localparam int SLOT_U = SLOT_V + 1;
  localparam int SLOT_C = SLOT_V + 2;
  localparam int SLOT_P = SLOT_V + 3;

  logic [DW-1:0] word_q;
  logic          v_q, inv_q, line_q;
  logic [5:0]    hh;
  logic [4:0]    slot, didx;
  logic          half, cell_bit, parity, lvl;
  logic [7:0]    pat;

  assign hh   = pos[5:0];
  assign slot = hh[5:1];
  assign half = hh[0];
  assign didx = slot - 5'(SLOT_DATA0);
  assign parity = ^{word_q, v_q, u_bit, c_bit};

  always_comb begin
    if (slot == 5'(SLOT_V))      cell_bit = v_q;
    else if (slot == 5'(SLOT_U)) cell_bit = u_bit;
    else if (slot == 5'(SLOT_C)) cell_bit = c_bit;
    else if (slot == 5'(SLOT_P)) cell_bit = parity;
    else                         cell_bit = word_q[didx];
  end

  always_comb begin
    pat = sync_bits(sync_sel);
    if (hh < 6'(PRE_HC))
      lvl = pat[3'd7 - hh[2:0]] ^ ((hh == 6'd0) ? line_q : inv_q);
    else if (!half)
      lvl = ~line_q;
    else
      lvl = line_q ^ cell_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      v_q    <= 1'b0;
      inv_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      if (load_word) begin
        word_q <= word_in;
        v_q    <= v_in;
      end
      if (running && hh == 6'd0) inv_q <= line_q;
      line_q <= running ? lvl : 1'b0;
    end
  end

  assign line = line_q;

  p_slot_edge_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (hh >= 6'(PRE_HC)) && !half) |=> (line_q != $past(line_q)));

  p_sync_returns_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hh == 6'd7) |=> (line_q == $past(inv_q)));
endmodule

// File: rtl/spdif_line_tx.sv
module spdif_line_tx import spdif_tx_pkg::*; #(
  parameter int FRAMES = 192,
  parameter int DW     = 24,
  localparam int FW    = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              null_valid,
  input  logic              valid_ch1,
  input  logic              valid_ch2,
  input  logic              underrun_clr,
  input  logic [FRAMES-1:0] cs_bank,
  input  logic [FRAMES-1:0] ud_bank,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DW-1:0]     smp_data,
  output logic              line_out,
  output logic              evt_block_end,
  output logic              evt_cs_ready,
  output logic              evt_ud_ready,
  output logic              underrun_flag
);
  logic             running, sf_start, blk_start, blk_last, ch_sel;
  logic [POS_W-1:0] pos;
  logic [FW-1:0]    frame;
  logic             underrun_q, blk_end_q, v_next;
  sync_e            sync_sel;
  logic [DW-1:0]    word_next;

  logic [1:0][FRAMES-1:0] bank_arr;
  logic [1:0]             meta_bit, meta_evt;

  spdif_tx_timing #(.FRAMES(FRAMES)) u_timing (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .running(running), .pos(pos),
    .frame(frame), .sf_start(sf_start), .blk_start(blk_start), .blk_last(blk_last)
  );

  assign bank_arr[0] = cs_bank;
  assign bank_arr[1] = ud_bank;

  for (genvar g = 0; g < 2; g++) begin : g_meta
    spdif_tx_shadow #(.FRAMES(FRAMES)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(blk_start), .frame_idx(frame),
      .bank(bank_arr[g]), .bit_out(meta_bit[g]), .loaded_evt(meta_evt[g])
    );
  end

  assign ch_sel    = pos[POS_W-1];
  assign sync_sel  = ch_sel ? SYNC_CH2 : ((frame == '0) ? SYNC_BLOCK : SYNC_CH1);
  assign word_next = smp_valid ? smp_data : '0;
  assign v_next    = smp_valid ? (ch_sel ? valid_ch2 : valid_ch1) : ~null_valid;

  spdif_tx_bmc #(.DW(DW)) u_bmc (
    .clk(clk), .rst_n(rst_n), .running(running), .pos(pos), .sync_sel(sync_sel),
    .load_word(sf_start), .word_in(word_next), .v_in(v_next),
    .u_bit(meta_bit[1]), .c_bit(meta_bit[0]), .line(line_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun_q <= 1'b0;
      blk_end_q  <= 1'b0;
    end else begin
      blk_end_q <= blk_last;
      if (sf_start && !smp_valid) underrun_q <= 1'b1;
      else if (underrun_clr)      underrun_q <= 1'b0;
    end
  end

  assign smp_ready     = sf_start;
  assign evt_block_end = blk_end_q;
  assign evt_cs_ready  = meta_evt[0];
  assign evt_ud_ready  = meta_evt[1];
  assign underrun_flag = underrun_q;

  p_pull_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !smp_ready);

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_flag && !underrun_clr) |=> underrun_flag);

  p_idle_line_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !line_out);

  p_block_end_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_block_end |=> !evt_block_end);
endmodule

// File: tb/spdif_line_tx_tb.sv
module spdif_line_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, null_valid = 0, valid_ch1 = 0, valid_ch2 = 0, underrun_clr = 0, smp_valid = 0;
  logic [191:0] cs_bank, ud_bank;
  logic [23:0] smp_data = 24'h5A3C96;
  logic smp_ready, line_out, evt_block_end, evt_cs_ready, evt_ud_ready, underrun_flag;

  spdif_line_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .null_valid(null_valid),
    .valid_ch1(valid_ch1), .valid_ch2(valid_ch2), .underrun_clr(underrun_clr),
    .cs_bank(cs_bank), .ud_bank(ud_bank), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .line_out(line_out), .evt_block_end(evt_block_end),
    .evt_cs_ready(evt_cs_ready), .evt_ud_ready(evt_ud_ready), .underrun_flag(underrun_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  bit m_run, m_under, e_line, e_cs, e_ud, e_blk, hs_flag;
  int m_pos, m_frame, sidx = 0, n_cs_evt = 0, n_blk_evt = 0;
  bit [191:0] m_cs, m_ud;
  bit sf [64];

  function automatic bit [23:0] gen_word(int k);
    return 24'((k * 40503) ^ (k << 9) ^ 24'h5A3C96);
  endfunction

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic build_sf(int ptype, bit prev, bit [23:0] w, bit v, bit u, bit c);
    bit [7:0] pat;
    bit lv, b, par;
    int n;
    pat = (ptype == 0) ? 8'hE8 : (ptype == 1) ? 8'hE2 : 8'hE4;
    for (int i = 0; i < 8; i++) sf[i] = pat[7-i] ^ prev;
    lv = prev; n = 8; par = 0;
    for (int s = 4; s < 32; s++) begin
      if (s < 28) b = w[s-4];
      else if (s == 28) b = v;
      else if (s == 29) b = u;
      else if (s == 30) b = c;
      else b = par;
      par ^= b;
      lv = ~lv; sf[n] = lv; n++;
      if (b) lv = ~lv;
      sf[n] = lv; n++;
    end
  endtask

  // Behavioural reference: what the registered outputs hold after each edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_under = 0; e_line = 0; e_cs = 0; e_ud = 0; e_blk = 0;
      m_pos = 0; m_frame = 0; m_cs = '0; m_ud = '0; hs_flag = 0;
    end else begin
      e_cs = 0; e_ud = 0; e_blk = 0;
      if (m_run && (m_pos % 64 == 0) && !smp_valid) m_under = 1;
      else if (underrun_clr) m_under = 0;
      if (!m_run) begin
        e_line = 0;
        if (tx_en) begin m_run = 1; m_pos = 0; m_frame = 0; end
      end else begin
        if (m_pos % 64 == 0) begin
          int ch;
          bit v;
          bit [23:0] w;
          ch = m_pos / 64;
          if (m_pos == 0 && m_frame == 0) begin
            m_cs = cs_bank; m_ud = ud_bank; e_cs = 1; e_ud = 1;
          end
          v = smp_valid ? (ch == 1 ? valid_ch2 : valid_ch1) : !null_valid;
          w = smp_valid ? smp_data : 24'd0;
          if (smp_valid) hs_flag = 1;
          build_sf(ch == 1 ? 2 : (m_frame == 0 ? 0 : 1), e_line, w, v, m_ud[m_frame], m_cs[m_frame]);
        end
        e_line = sf[m_pos % 64];
        if (m_frame == FRAMES - 1 && m_pos == 127) e_blk = 1;
        m_pos++;
        if (m_pos == 128) begin
          m_pos = 0;
          if (!tx_en) begin m_run = 0; m_frame = 0; end
          else m_frame = (m_frame + 1) % FRAMES;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(line_out, e_line, cur_req, "line_out");
      chk(smp_ready, (m_run && (m_pos % 64 == 0)) ? 1 : 0, "R2", "smp_ready");
      chk(evt_cs_ready, e_cs, "R8", "evt_cs_ready");
      chk(evt_ud_ready, e_ud, "R8", "evt_ud_ready");
      chk(evt_block_end, e_blk, "R9", "evt_block_end");
      chk(underrun_flag, m_under, "R10", "underrun_flag");
      if (evt_cs_ready) n_cs_evt++;
      if (evt_block_end) n_blk_evt++;
    end
    if (hs_flag) begin
      hs_flag = 0;
      sidx++;
      smp_data = gen_word(sidx);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cs_bank = {32'h0000_00F3, 32'h8001_2200, 32'h0F0F_F0F0, 32'h1234_5678, 32'hFFFF_0000, 32'h0200_0104};
    ud_bank = {32'hDEAD_BEEF, 32'h0000_0001, 32'h8000_0000, 32'h3C3C_A5A5, 32'h0101_0101, 32'h7F00_00FE};
    wait_cyc(3);
    chk(line_out, 0, "R1", "line_out in reset");
    chk(smp_ready, 0, "R1", "smp_ready in reset");
    chk(evt_block_end | evt_cs_ready | evt_ud_ready, 0, "R1", "events in reset");
    chk(underrun_flag, 0, "R1", "underrun in reset");
    rst_n = 1;
    wait_cyc(2);
    chk(line_out, 0, "R1", "line_out after reset");
    // R4: start of a block, sync patterns; R3: subframe contents.
    cur_req = "R4"; valid_ch1 = 0; valid_ch2 = 1; smp_valid = 1; tx_en = 1;
    wait_cyc(3 * 128);
    cur_req = "R3";
    wait_cyc(97 * 128);
    // R7: bank rewrite mid-block must only show in the next block.
    cur_req = "R7";
    cs_bank = {32'hA5A5_5A5A, 32'h0000_FFFF, 32'h1111_2222, 32'h00C0_FFEE, 32'h8421_1248, 32'h0000_0006};
    ud_bank = {32'h0F1E_2D3C, 32'hFFFF_FFFF, 32'h0000_0000, 32'h5555_AAAA, 32'h1357_9BDF, 32'h2468_ACE0};
    wait_cyc(96 * 128);
    // R6: validity bits swapped.
    cur_req = "R6"; valid_ch1 = 1; valid_ch2 = 0;
    wait_cyc(2 * 128);
    // R10: starve the source, then clear the flag.
    cur_req = "R10"; smp_valid = 0;
    wait_cyc(200);
    smp_valid = 1;
    wait_cyc(100);
    underrun_clr = 1;
    wait_cyc(1);
    underrun_clr = 0;
    wait_cyc(200);
    // R11: null subframes marked valid.
    cur_req = "R11"; null_valid = 1; smp_valid = 0;
    wait_cyc(150);
    smp_valid = 1;
    wait_cyc(100);
    // R5: stop mid-frame, restart begins a new block.
    cur_req = "R5"; tx_en = 0;
    wait_cyc(400);
    cur_req = "R4"; tx_en = 1;
    wait_cyc(3 * 128);
    cur_req = "R5"; tx_en = 0;
    wait_cyc(300);
    chk(n_cs_evt, 3, "R8", "status copy events");
    chk(n_blk_evt, 1, "R9", "block end events");
    chk(line_out, 0, "R5", "line after stop");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule